// File: doc/BRIEF.md
# Interrupt Line to Message Write Redirector

This block watches a small group of interrupt input wires and turns each activation into one outgoing write request. The request carries a programmed 8-bit data byte, a destination ID and an extended destination ID. Each line has its own entry. The entry sets its input polarity, its trigger style (edge or level), its mask and the fields of its message. Software reaches every entry indirectly. It writes an internal index into a selector at port offset 0x00, then reads or writes the 32-bit word at the window offset 0x10. A write to the end-of-interrupt port at offset 0x40 releases a level-triggered line that was served.

Each input passes through a two-stage synchroniser and is then inverted if its polarity is active-low. An edge line raises a pending flag on every rising edge of this normalised input. A level line raises one request when it becomes active while unmasked and idle, and then stays in service until software writes its number to the end-of-interrupt port. When more than one line is waiting, the lowest-numbered line is launched first. A launched request is held in an output register with valid/ready handshaking, and its fields do not change until ready is accepted.

Top module: `irq_msg_redirect`

## Requirements
- R1: After reset, msg_valid is 0, every low entry word reads 0x0001_0000 (line masked, edge, active-high, data 0) and every high entry word reads 0.
- R2: Internal index 0x01 reads as a version word. Bits 7:0 hold the VERSION parameter, bits 23:16 hold NUM_LINES-1, and all other bits are zero.
- R3: The low word of line n is at index 0x10+2n and keeps bits 7:0 (data byte), 13 (active-low), 15 (level) and 16 (mask). The high word is at index 0x11+2n and keeps bits 31:24 (destination ID) and 23:16 (extended ID). All other bits read back as 0.
- R4: A window access to an index that is neither 0x01 nor an entry of an implemented line reads as zero, and a write to such an index changes no stored state.
- R5: An unmasked edge line sends exactly one message per rising edge of its normalised input. The message carries that line's data byte, destination ID and extended ID, and no end-of-interrupt is needed before the next edge.
- R6: With bit 13 set, the input is inverted before trigger detection, so a falling wire produces a message and a rising wire produces none.
- R7: An unmasked level line that is held active sends exactly one message and then stays silent while it is in service.
- R8: Writing line number n to offset 0x40 clears that line's in-service state. If the line is still active, a new message follows; if it is inactive, none follows. An end-of-interrupt that names another line has no effect.
- R9: A line with mask bit 16 set produces no message, whether it is edge-triggered or level-triggered.
- R10: When several lines are waiting at once, their messages go out in ascending line order.
- R11: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_dest, msg_ext and msg_data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt wires, asynchronous |
| reg_addr | input | 7 | Register port offset: 0x00 selector, 0x10 window, 0x40 end-of-interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| msg_valid | output | 1 | Outgoing write request valid |
| msg_ready | input | 1 | Outgoing write request accepted |
| msg_dest | output | 8 | Destination ID of the request |
| msg_ext | output | 8 | Extended destination ID of the request |
| msg_data | output | 8 | Data byte of the request |

## Verification
Wrong pending or in-service state shows up at the message port within a few cycles. It appears as a missing message, a duplicate message, or a message carrying another line's data byte, which is unique per line in the sweeps. A lost in-service bit on a held level line produces a second message within about four cycles of the first, long before any end-of-interrupt. A wrong arbitration order or a field that changes during a stall shows up in the captured message sequence and in the fields sampled while ready is held low. Entry storage faults appear at once on window readback.

// File: rtl/irm_pkg.sv
package irm_pkg;
  localparam int MAX_LINES = 7;

  localparam logic [6:0] OFS_SELECT = 7'h00;
  localparam logic [6:0] OFS_WINDOW = 7'h10;
  localparam logic [6:0] OFS_EOI    = 7'h40;

  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam int         IDX_ENTRY   = 16;

  localparam int LO_POL_BIT  = 13;
  localparam int LO_LVL_BIT  = 15;
  localparam int LO_MASK_BIT = 16;

  function automatic logic [31:0] pack_lo(logic mask, logic lvl, logic pol, logic [7:0] data);
    logic [31:0] w;
    w = {24'h0, data};
    w[LO_POL_BIT]  = pol;
    w[LO_LVL_BIT]  = lvl;
    w[LO_MASK_BIT] = mask;
    return w;
  endfunction

  function automatic logic [31:0] pack_hi(logic [7:0] dest, logic [7:0] ext);
    return {dest, ext, 16'h0};
  endfunction

  function automatic logic [31:0] version_word(logic [7:0] ver, logic [7:0] last_idx);
    return {8'h00, last_idx, 8'h00, ver};
  endfunction
endpackage

// File: rtl/irm_line.sv
module irm_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic pol_low,
  input  logic level,
  input  logic mask,
  input  logic launch,
  input  logic eoi,
  output logic req,
  output logic inserv
);
  logic s1_q, s2_q, prev_q, pend_q;
  logic norm, rise, fire;

  assign norm = s2_q ^ pol_low;
  assign rise = norm & ~prev_q;
  assign fire = level ? (norm & ~mask & ~inserv & ~launch) : (rise & ~mask);
  assign req  = pend_q & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      inserv <= 1'b0;
    end else begin
      s1_q   <= irq_raw;
      s2_q   <= s1_q;
      prev_q <= norm;
      pend_q <= (pend_q & ~launch) | fire;
      if (launch && level) inserv <= 1'b1;
      else if (eoi)        inserv <= 1'b0;
    end
  end
endmodule

// File: rtl/irm_pick.sv
module irm_pick #(
  parameter int N = 7
) (
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  assign grant = en ? (req & (~req + N'(1))) : '0;
endmodule

// File: rtl/irq_msg_redirect.sv
module irq_msg_redirect #(
  parameter int         NUM_LINES = 7,
  parameter logic [7:0] VERSION   = 8'h11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [6:0]           reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_dest,
  output logic [7:0]           msg_ext,
  output logic [7:0]           msg_data
);
  import irm_pkg::*;

  localparam logic [7:0] LAST_IDX = 8'(NUM_LINES - 1);

  logic [7:0] sel_q;
  logic       wr_sel, wr_win, wr_eoi;

  logic [NUM_LINES-1:0]      ent_mask, ent_lvl, ent_pol;
  logic [NUM_LINES-1:0][7:0] ent_data, ent_dest, ent_ext;
  logic [NUM_LINES-1:0]      line_req, line_launch, line_inserv, line_level;

  assign wr_sel = reg_we && (reg_addr == OFS_SELECT);
  assign wr_win = reg_we && (reg_addr == OFS_WINDOW);
  assign wr_eoi = reg_we && (reg_addr == OFS_EOI);
  assign line_level = ent_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 8'h00;
    else if (wr_sel) sel_q <= reg_wdata[7:0];
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam logic [7:0] LO_IDX = 8'(IDX_ENTRY + 2 * n);
    localparam logic [7:0] HI_IDX = 8'(IDX_ENTRY + 2 * n + 1);
    logic       mask_q, lvl_q, pol_q;
    logic [7:0] data_q, dest_q, ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= 1'b1;
        lvl_q  <= 1'b0;
        pol_q  <= 1'b0;
        data_q <= 8'h00;
        dest_q <= 8'h00;
        ext_q  <= 8'h00;
      end else if (wr_win && sel_q == LO_IDX) begin
        mask_q <= reg_wdata[LO_MASK_BIT];
        lvl_q  <= reg_wdata[LO_LVL_BIT];
        pol_q  <= reg_wdata[LO_POL_BIT];
        data_q <= reg_wdata[7:0];
      end else if (wr_win && sel_q == HI_IDX) begin
        dest_q <= reg_wdata[31:24];
        ext_q  <= reg_wdata[23:16];
      end
    end

    assign ent_mask[n] = mask_q;
    assign ent_lvl[n]  = lvl_q;
    assign ent_pol[n]  = pol_q;
    assign ent_data[n] = data_q;
    assign ent_dest[n] = dest_q;
    assign ent_ext[n]  = ext_q;

    irm_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_raw (irq_in[n]),
      .pol_low (pol_q),
      .level   (lvl_q),
      .mask    (mask_q),
      .launch  (line_launch[n]),
      .eoi     (wr_eoi && reg_wdata == 32'(n)),
      .req     (line_req[n]),
      .inserv  (line_inserv[n])
    );
  end

  irm_pick #(.N(NUM_LINES)) u_pick (
    .en    (~msg_valid),
    .req   (line_req),
    .grant (line_launch)
  );

  logic [31:0] win_rdata;
  always_comb begin
    win_rdata = '0;
    if (sel_q == IDX_VERSION) win_rdata = version_word(VERSION, LAST_IDX);
    for (int n = 0; n < NUM_LINES; n++) begin
      if (sel_q == 8'(IDX_ENTRY + 2 * n))
        win_rdata = pack_lo(ent_mask[n], ent_lvl[n], ent_pol[n], ent_data[n]);
      if (sel_q == 8'(IDX_ENTRY + 2 * n + 1))
        win_rdata = pack_hi(ent_dest[n], ent_ext[n]);
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_SELECT: reg_rdata = {24'h0, sel_q};
      OFS_WINDOW: reg_rdata = win_rdata;
      default:    reg_rdata = '0;
    endcase
  end

  logic [7:0] pick_dest, pick_ext, pick_data;
  always_comb begin
    pick_dest = '0;
    pick_ext  = '0;
    pick_data = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (line_launch[n]) begin
        pick_dest = ent_dest[n];
        pick_ext  = ent_ext[n];
        pick_data = ent_data[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_dest  <= 8'h00;
      msg_ext   <= 8'h00;
      msg_data  <= 8'h00;
    end else if (!msg_valid && |line_launch) begin
      msg_valid <= 1'b1;
      msg_dest  <= pick_dest;
      msg_ext   <= pick_ext;
      msg_data  <= pick_data;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irm_checker.sv
module irm_checker #(
  parameter int N = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_valid,
  input logic         msg_ready,
  input logic [7:0]   msg_dest,
  input logic [7:0]   msg_ext,
  input logic [7:0]   msg_data,
  input logic [N-1:0] line_launch,
  input logic [N-1:0] line_inserv,
  input logic [N-1:0] line_level
);
  a_r11_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_ext) && $stable(msg_data)));

  a_r10_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_launch));

  a_r10_launch_fills_output: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_launch) |=> msg_valid);

  a_r7_no_launch_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (line_inserv & line_level & line_launch) == '0);
endmodule

bind irq_msg_redirect irm_checker #(.N(NUM_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_dest    (msg_dest),
  .msg_ext     (msg_ext),
  .msg_data    (msg_data),
  .line_launch (line_launch),
  .line_inserv (line_inserv),
  .line_level  (line_level)
);

// File: tb/sim_irq_msg_redirect.sv
`timescale 1ns/1ps
module sim_irq_msg_redirect;
  localparam int         NL  = 7;
  localparam logic [7:0] VER = 8'h11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] irq_in;
  logic [6:0]    reg_addr;
  logic          reg_we;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          msg_valid, msg_ready;
  logic [7:0]    msg_dest, msg_ext, msg_data;

  always #5 clk = ~clk;

  irq_msg_redirect #(.NUM_LINES(NL), .VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_ext(msg_ext), .msg_data(msg_data)
  );

  int tests = 0;
  int fails = 0;
  int cap_cnt = 0;
  logic [7:0] cap_data [64];
  logic [7:0] cap_dest [64];
  logic [7:0] cap_ext  [64];

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && cap_cnt < 64) begin
      cap_data[cap_cnt] = msg_data;
      cap_dest[cap_cnt] = msg_dest;
      cap_ext[cap_cnt]  = msg_ext;
      cap_cnt = cap_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #2;
    reg_we = 1'b0;
  endtask

  task automatic wr_win(input logic [7:0] idx, input logic [31:0] d);
    wr(7'h00, {24'h0, idx});
    wr(7'h10, d);
  endtask

  task automatic rd_win(input logic [7:0] idx, output logic [31:0] d);
    wr(7'h00, {24'h0, idx});
    reg_addr = 7'h10;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    irq_in[n] = 1'b1; idle(4);
    irq_in[n] = 1'b0; idle(4);
  endtask

  function automatic logic [31:0] lo_exp(int mask, int lvl, int pol, int data);
    return (mask << 16) | (lvl << 15) | (pol << 13) | (data & 255);
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    irq_in = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; msg_ready = 1'b1; rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    chk("R1 valid after reset", {31'h0, msg_valid}, 32'h0);
    for (int n = 0; n < NL; n++) begin
      rd_win(8'(16 + 2 * n), d); chk("R1 low word reset", d, lo_exp(1, 0, 0, 0));
      rd_win(8'(17 + 2 * n), d); chk("R1 high word reset", d, 32'h0);
    end

    rd_win(8'h01, d);
    chk("R2 version", d, ((NL - 1) << 16) | VER);

    for (int n = 0; n < NL; n++) begin
      wr_win(8'(16 + 2 * n), 32'hFFFF_FFFF);
      rd_win(8'(16 + 2 * n), d); chk("R3 low bits kept", d, lo_exp(1, 1, 1, 255));
      wr_win(8'(17 + 2 * n), 32'hFFFF_FFFF);
      rd_win(8'(17 + 2 * n), d); chk("R3 high bits kept", d, 32'hFFFF_0000);
    end

    foreach (d[i]) begin end
    for (int k = 0; k < 8; k++) begin
      logic [7:0] idx;
      case (k)
        0: idx = 8'h00; 1: idx = 8'h02; 2: idx = 8'h03; 3: idx = 8'h0F;
        4: idx = 8'(16 + 2 * NL); 5: idx = 8'(17 + 2 * NL); 6: idx = 8'h40; default: idx = 8'hFF;
      endcase
      wr_win(idx, 32'hFFFF_FFFF);
      rd_win(idx, d); chk("R4 unimplemented reads zero", d, 32'h0);
    end
    rd_win(8'h10, d); chk("R4 write ignored, line0 intact", d, lo_exp(1, 1, 1, 255));

    for (int n = 0; n < NL; n++) begin
      wr_win(8'(17 + 2 * n), {8'(8'h10 + n), 8'(8'hA0 + n), 16'h0});
      wr_win(8'(16 + 2 * n), lo_exp(0, 0, 0, 8'h40 + n));
    end
    idle(20);
    chk("R5 no spurious message", cap_cnt, 0);

    for (int n = 0; n < NL; n++) begin
      base = cap_cnt;
      pulse(n); idle(20);
      chk("R5 one message per edge", cap_cnt, base + 1);
      chk("R5 data byte", cap_data[base], 8'h40 + n);
      chk("R5 destination", cap_dest[base], 8'h10 + n);
      chk("R5 extended id", cap_ext[base], 8'hA0 + n);
    end
    base = cap_cnt;
    pulse(0); idle(10); pulse(0); idle(20);
    chk("R5 repeated edges, no EOI", cap_cnt, base + 2);

    base = cap_cnt;
    wr_win(8'h14, lo_exp(1, 0, 1, 8'h42)); idle(10);
    wr_win(8'h14, lo_exp(0, 0, 1, 8'h42)); idle(10);
    chk("R6 polarity switch while masked", cap_cnt, base);
    irq_in[2] = 1'b1; idle(15);
    chk("R6 rising wire silent when active-low", cap_cnt, base);
    irq_in[2] = 1'b0; idle(15);
    chk("R6 falling wire fires when active-low", cap_cnt, base + 1);
    chk("R6 data byte", cap_data[base], 8'h42);
    wr_win(8'h14, lo_exp(1, 0, 0, 8'h42)); idle(10);
    wr_win(8'h14, lo_exp(0, 0, 0, 8'h42)); idle(10);

    base = cap_cnt;
    wr_win(8'h16, lo_exp(0, 1, 0, 8'h43));
    irq_in[3] = 1'b1; idle(30);
    chk("R7 held level sends one message", cap_cnt, base + 1);
    chk("R7 data byte", cap_data[base], 8'h43);
    wr(7'h40, 32'd4); idle(20);
    chk("R8 EOI for another line ignored", cap_cnt, base + 1);
    wr(7'h40, 32'd3); idle(20);
    chk("R8 EOI while active re-issues", cap_cnt, base + 2);
    irq_in[3] = 1'b0; idle(5);
    wr(7'h40, 32'd3); idle(20);
    chk("R8 EOI while inactive is silent", cap_cnt, base + 2);
    irq_in[3] = 1'b1; idle(20);
    chk("R7 new activation after EOI", cap_cnt, base + 3);
    irq_in[3] = 1'b0; idle(5);
    wr(7'h40, 32'd3); idle(10);

    base = cap_cnt;
    wr_win(8'h18, lo_exp(1, 0, 0, 8'h44));
    pulse(4); idle(20);
    chk("R9 masked edge line silent", cap_cnt, base);
    wr_win(8'h18, lo_exp(1, 1, 0, 8'h44));
    irq_in[4] = 1'b1; idle(20);
    chk("R9 masked level line silent", cap_cnt, base);
    irq_in[4] = 1'b0; idle(5);
    wr_win(8'h18, lo_exp(0, 0, 0, 8'h44)); idle(20);
    chk("R9 unmask with idle wire silent", cap_cnt, base);

    base = cap_cnt;
    msg_ready = 1'b0;
    irq_in[6] = 1'b1; irq_in[5] = 1'b1; irq_in[0] = 1'b1;
    idle(10);
    chk("R11 valid held while stalled", {31'h0, msg_valid}, 32'h1);
    chk("R10 lowest line first", msg_data, 8'h40);
    for (int c = 0; c < 5; c++) begin
      idle(1);
      chk("R11 fields stable", {msg_valid, msg_dest, msg_ext, msg_data}, {1'b1, 8'h10, 8'hA0, 8'h40});
    end
    irq_in = '0;
    msg_ready = 1'b1;
    idle(30);
    chk("R10 all three delivered", cap_cnt, base + 3);
    chk("R10 order first", cap_data[base], 8'h40);
    chk("R10 order second", cap_data[base + 1], 8'h45);
    chk("R10 order third", cap_data[base + 2], 8'h46);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule